// File: doc/BRIEF.md
# Secure-attribute access filter

This block sits between one bus master port and a small set of memory-mapped targets on an AXI-style interface with separate read-address, read-data, write-address, write-data and write-response channels. Each address request carries a one-bit security attribute in its protection field. The filter uses that bit either to pick the target or to refuse the request. One numeric address can therefore name two distinct locations, or it can be allowed for one world and refused for the other.

A parameter selects one of two variants. In the alias variant, the attribute acts as the top bit of the target index. Secure and non-secure requests to the same address then land on different targets. In the gating variant, the target is chosen from address bits alone. A parameter-defined list of power-of-two regions, each flagged secure or open, is checked against every non-secure request. A refused request is absorbed by the filter, which produces an error response of the correct shape itself. Such a request never raises a valid toward any target.

Read and write channels have independent control, and each handles one transaction at a time. A refused read that is waiting on the master's ready never holds up a write, and the reverse is also true.

Top module: `secfilt`

## Requirements
- R1: The security attribute is bit 1 of the 3-bit protection field of both address channels (0 = secure, 1 = non-secure). While reset is held, every target-side valid and the master-side write-response and read-data valids are low.
- R2: Alias variant (MODE=0): the target index is {prot[1], addr[WIN_LOG2 +: TGT_W-1]}. With the default of four targets and 4 KiB windows, a secure request to 0x1900 goes to target 1 and a non-secure request to 0x1900 goes to target 3.
- R3: Gating variant (MODE=1): the target index is addr[WIN_LOG2 +: TGT_W]. Addresses 0x0000, 0x1000, 0x2000 and 0x3000 map to targets 0 to 3.
- R4: Gating variant: a non-secure request that matches a secure region is accepted on the master side in the same cycle as its valid, and no target valid is raised for it.
- R5: Secure requests reach every region. Non-secure requests reach open regions and addresses that no region matches. At most one target address valid is high per channel.
- R6: A region matches when (addr & ~(2^size-1)) equals (base & ~(2^size-1)). When regions overlap, the lowest-numbered matching region decides. The defaults are: region 0 = 0x1000, 2 KiB, open; region 1 = 0x1000, 4 KiB, secure; region 2 = 0x3000, 4 KiB, secure.
- R7: A refused write keeps write-ready high until the beat flagged last has been taken. In the next cycle it raises one write response coded 2'b10.
- R8: A refused read with length field L returns L+1 beats with response 2'b10 and data zero. Only the final beat carries last. Read valid is low in the cycle after that beat is taken.
- R9: The read and write channels proceed independently. A write completes while a refused read sits unconsumed.
- R10: An allowed request is forwarded to the selected target in the same cycle. That target's ready, data and responses pass through to the master until the write response or the last read beat is taken. Response code 2'b00 means success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mAwvalid | input | 1 | Master write-address valid |
| mAwready | output | 1 | Master write-address ready |
| mAwaddr | input | ADDR_W | Write address |
| mAwprot | input | 3 | Write protection field; bit 1 is the attribute |
| mAwlen | input | LEN_W | Write burst length minus one |
| mWvalid | input | 1 | Write-data valid |
| mWready | output | 1 | Write-data ready |
| mWdata | input | DATA_W | Write data |
| mWlast | input | 1 | Final write beat |
| mBvalid | output | 1 | Write-response valid |
| mBready | input | 1 | Write-response ready |
| mBresp | output | 2 | Write response code |
| mArvalid | input | 1 | Read-address valid |
| mArready | output | 1 | Read-address ready |
| mAraddr | input | ADDR_W | Read address |
| mArprot | input | 3 | Read protection field; bit 1 is the attribute |
| mArlen | input | LEN_W | Read burst length minus one |
| mRvalid | output | 1 | Read-data valid |
| mRready | input | 1 | Read-data ready |
| mRdata | output | DATA_W | Read data |
| mRresp | output | 2 | Read response code |
| mRlast | output | 1 | Final read beat |
| tAwvalid | output | NUM_TGT | Per-target write-address valid |
| tAwready | input | NUM_TGT | Per-target write-address ready |
| tAwaddr | output | ADDR_W | Shared write address toward targets |
| tAwprot | output | 3 | Shared write protection field |
| tAwlen | output | LEN_W | Shared write length |
| tWvalid | output | NUM_TGT | Per-target write-data valid |
| tWready | input | NUM_TGT | Per-target write-data ready |
| tWdata | output | DATA_W | Shared write data |
| tWlast | output | 1 | Shared last-beat flag |
| tBvalid | input | NUM_TGT | Per-target write-response valid |
| tBready | output | NUM_TGT | Per-target write-response ready |
| tBresp | input | 2*NUM_TGT | Per-target write response codes |
| tArvalid | output | NUM_TGT | Per-target read-address valid |
| tArready | input | NUM_TGT | Per-target read-address ready |
| tAraddr | output | ADDR_W | Shared read address |
| tArprot | output | 3 | Shared read protection field |
| tArlen | output | LEN_W | Shared read length |
| tRvalid | input | NUM_TGT | Per-target read-data valid |
| tRready | output | NUM_TGT | Per-target read-data ready |
| tRdata | input | DATA_W*NUM_TGT | Per-target read data |
| tRresp | input | 2*NUM_TGT | Per-target read response codes |
| tRlast | input | NUM_TGT | Per-target last-beat flags |

## Verification
The permit or refuse decision and the forwarded target valid appear in the same cycle as the master's address valid. The bench therefore checks them one time unit after the falling edge at which the request is driven, before the accepting rising edge. A refused write's error response and a forwarded target's response both become visible in the cycle after the last write beat is taken. Error read beats, like forwarded read beats, start in the cycle after the read-address handshake and advance once per cycle in which the master is ready. Each beat is compared at the falling edge that follows the previous handshake. Both variants are built side by side from the same master stimulus, so every pair of requests that differ only in the attribute bit shows its different outcome in the same cycle.

// File: rtl/secfilt_pkg.sv
package secfilt_pkg;

  localparam int MODE_ALIAS = 0;
  localparam int MODE_GATE  = 1;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic awFwd;
    logic awLoad;
    logic wFwd;
    logic wSink;
    logic bFwd;
    logic bErr;
    logic arFwd;
    logic arLoad;
    logic rFwd;
    logic rErr;
    logic rErrLast;
  } strobes_t;

endpackage

// File: rtl/secfilt_decode.sv
module secfilt_decode
  import secfilt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_TGT = 4,
  parameter int WIN_LOG2 = 12,
  parameter int MODE = MODE_GATE,
  parameter int NUM_REG = 3,
  parameter logic [NUM_REG*ADDR_W-1:0] REG_BASE = '0,
  parameter logic [NUM_REG*6-1:0] REG_SIZE_LOG2 = '0,
  parameter logic [NUM_REG-1:0] REG_SECURE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic nonSecure,
  output logic [$clog2(NUM_TGT)-1:0] tgt,
  output logic blocked
);

  localparam int TGT_W = $clog2(NUM_TGT);

  generate
    if (MODE == MODE_ALIAS) begin : g_alias
      // attribute becomes the top bit of the target index
      assign tgt = {nonSecure, addr[WIN_LOG2 +: TGT_W-1]};
      assign blocked = 1'b0;
    end else begin : g_gate
      logic hitSecure;
      always_comb begin
        hitSecure = 1'b0;
        // scan from the highest index down so the lowest match decides
        for (int i = NUM_REG - 1; i >= 0; i--) begin
          logic [ADDR_W-1:0] mask;
          mask = {ADDR_W{1'b1}} << REG_SIZE_LOG2[i*6 +: 6];
          if ((addr & mask) == (REG_BASE[i*ADDR_W +: ADDR_W] & mask)) begin
            hitSecure = REG_SECURE[i];
          end
        end
      end
      assign tgt = addr[WIN_LOG2 +: TGT_W];
      assign blocked = nonSecure && hitSecure;
    end
  endgenerate

endmodule

// File: rtl/secfilt_ctrl.sv
module secfilt_ctrl
  import secfilt_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic awvalid,
  input  logic awBlocked,
  input  logic selAwready,
  input  logic wvalid,
  input  logic wlast,
  input  logic selWready,
  input  logic bready,
  input  logic selBvalid,
  input  logic arvalid,
  input  logic arBlocked,
  input  logic [LEN_W-1:0] arlen,
  input  logic selArready,
  input  logic rready,
  input  logic selRvalid,
  input  logic selRlast,
  output strobes_t st,
  output logic awready,
  output logic wready,
  output logic bvalid,
  output logic arready,
  output logic rvalid
);

  typedef enum logic [2:0] {W_IDLE, W_DATA, W_RESP, W_SINK, W_ERR} wState_t;
  typedef enum logic [1:0] {R_IDLE, R_DATA, R_ERR} rState_t;

  wState_t wState, wNext;
  rState_t rState, rNext;
  logic [LEN_W-1:0] rCnt, rCntNext;

  // write channel
  always_comb begin
    st.awFwd  = (wState == W_IDLE) && awvalid && !awBlocked;
    awready   = (wState == W_IDLE) && (awBlocked || selAwready);
    st.awLoad = (wState == W_IDLE) && awvalid && awready;
    st.wFwd   = (wState == W_DATA);
    st.wSink  = (wState == W_SINK);
    wready    = st.wFwd ? selWready : st.wSink;
    st.bFwd   = (wState == W_RESP);
    st.bErr   = (wState == W_ERR);
    bvalid    = st.bFwd ? selBvalid : st.bErr;

    wNext = wState;
    unique case (wState)
      W_IDLE: if (st.awLoad) wNext = awBlocked ? W_SINK : W_DATA;
      W_DATA: if (wvalid && wready && wlast) wNext = W_RESP;
      W_SINK: if (wvalid && wlast) wNext = W_ERR;
      W_RESP: if (bvalid && bready) wNext = W_IDLE;
      W_ERR:  if (bready) wNext = W_IDLE;
      default: wNext = W_IDLE;
    endcase
  end

  // read channel
  always_comb begin
    st.arFwd    = (rState == R_IDLE) && arvalid && !arBlocked;
    arready     = (rState == R_IDLE) && (arBlocked || selArready);
    st.arLoad   = (rState == R_IDLE) && arvalid && arready;
    st.rFwd     = (rState == R_DATA);
    st.rErr     = (rState == R_ERR);
    st.rErrLast = st.rErr && (rCnt == '0);
    rvalid      = st.rFwd ? selRvalid : st.rErr;

    rNext = rState;
    rCntNext = rCnt;
    unique case (rState)
      R_IDLE: if (st.arLoad) begin
        rNext = arBlocked ? R_ERR : R_DATA;
        rCntNext = arlen;
      end
      R_DATA: if (rvalid && rready && selRlast) rNext = R_IDLE;
      R_ERR: if (rready) begin
        if (rCnt == '0) rNext = R_IDLE;
        else rCntNext = rCnt - 1'b1;
      end
      default: rNext = R_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wState <= W_IDLE;
      rState <= R_IDLE;
      rCnt   <= '0;
    end else begin
      wState <= wNext;
      rState <= rNext;
      rCnt   <= rCntNext;
    end
  end

  // R7: the error response follows the sunk last beat
  a_r7_err_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (wState == W_SINK && wvalid && wlast) |=> bvalid);

  // R9: a refused read is taken without waiting on any target
  a_r9_ar_not_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (rState == R_IDLE && arvalid && arBlocked) |-> arready);

  // R8: each taken error beat brings the remaining count one closer
  a_r8_beat_count: assert property (@(posedge clk) disable iff (!rstN)
    (rState == R_ERR && rready && rCnt != '0) |=> (rState == R_ERR && rCnt == $past(rCnt) - 1'b1));

endmodule

// File: rtl/secfilt_dpath.sv
module secfilt_dpath
  import secfilt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_TGT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  strobes_t st,
  input  logic [$clog2(NUM_TGT)-1:0] awTgt,
  input  logic [$clog2(NUM_TGT)-1:0] arTgt,
  input  logic mWvalid,
  input  logic mBready,
  input  logic mRready,
  input  logic [NUM_TGT-1:0] tAwready,
  input  logic [NUM_TGT-1:0] tWready,
  input  logic [NUM_TGT-1:0] tBvalid,
  input  logic [2*NUM_TGT-1:0] tBresp,
  input  logic [NUM_TGT-1:0] tArready,
  input  logic [NUM_TGT-1:0] tRvalid,
  input  logic [DATA_W*NUM_TGT-1:0] tRdata,
  input  logic [2*NUM_TGT-1:0] tRresp,
  input  logic [NUM_TGT-1:0] tRlast,
  output logic [NUM_TGT-1:0] tAwvalid,
  output logic [NUM_TGT-1:0] tWvalid,
  output logic [NUM_TGT-1:0] tBready,
  output logic [NUM_TGT-1:0] tArvalid,
  output logic [NUM_TGT-1:0] tRready,
  output logic selAwready,
  output logic selWready,
  output logic selBvalid,
  output logic selArready,
  output logic selRvalid,
  output logic selRlast,
  output logic [1:0] mBresp,
  output logic [DATA_W-1:0] mRdata,
  output logic [1:0] mRresp,
  output logic mRlast
);

  localparam int TGT_W = $clog2(NUM_TGT);

  logic [TGT_W-1:0] wSel, rSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wSel <= '0;
      rSel <= '0;
    end else begin
      if (st.awLoad) wSel <= awTgt;
      if (st.arLoad) rSel <= arTgt;
    end
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    assign tAwvalid[t] = st.awFwd && (awTgt == TGT_W'(t));
    assign tWvalid[t]  = st.wFwd && mWvalid && (wSel == TGT_W'(t));
    assign tBready[t]  = st.bFwd && mBready && (wSel == TGT_W'(t));
    assign tArvalid[t] = st.arFwd && (arTgt == TGT_W'(t));
    assign tRready[t]  = st.rFwd && mRready && (rSel == TGT_W'(t));
  end

  assign selAwready = tAwready[awTgt];
  assign selWready  = tWready[wSel];
  assign selBvalid  = tBvalid[wSel];
  assign selArready = tArready[arTgt];
  assign selRvalid  = tRvalid[rSel];
  assign selRlast   = tRlast[rSel];

  assign mBresp = st.bErr ? RESP_SLVERR : tBresp[wSel*2 +: 2];
  assign mRdata = st.rErr ? '0 : tRdata[rSel*DATA_W +: DATA_W];
  assign mRresp = st.rErr ? RESP_SLVERR : tRresp[rSel*2 +: 2];
  assign mRlast = st.rErr ? st.rErrLast : selRlast;

endmodule

// File: rtl/secfilt.sv
module secfilt
  import secfilt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W = 8,
  parameter int NUM_TGT = 4,
  parameter int WIN_LOG2 = 12,
  parameter int MODE = MODE_GATE,
  parameter int NUM_REG = 3,
  parameter logic [NUM_REG*ADDR_W-1:0] REG_BASE = {32'h0000_3000, 32'h0000_1000, 32'h0000_1000},
  parameter logic [NUM_REG*6-1:0] REG_SIZE_LOG2 = {6'd12, 6'd12, 6'd11},
  parameter logic [NUM_REG-1:0] REG_SECURE = 3'b110
) (
  input  logic clk,
  input  logic rstN,
  input  logic mAwvalid,
  output logic mAwready,
  input  logic [ADDR_W-1:0] mAwaddr,
  input  logic [2:0] mAwprot,
  input  logic [LEN_W-1:0] mAwlen,
  input  logic mWvalid,
  output logic mWready,
  input  logic [DATA_W-1:0] mWdata,
  input  logic mWlast,
  output logic mBvalid,
  input  logic mBready,
  output logic [1:0] mBresp,
  input  logic mArvalid,
  output logic mArready,
  input  logic [ADDR_W-1:0] mAraddr,
  input  logic [2:0] mArprot,
  input  logic [LEN_W-1:0] mArlen,
  output logic mRvalid,
  input  logic mRready,
  output logic [DATA_W-1:0] mRdata,
  output logic [1:0] mRresp,
  output logic mRlast,
  output logic [NUM_TGT-1:0] tAwvalid,
  input  logic [NUM_TGT-1:0] tAwready,
  output logic [ADDR_W-1:0] tAwaddr,
  output logic [2:0] tAwprot,
  output logic [LEN_W-1:0] tAwlen,
  output logic [NUM_TGT-1:0] tWvalid,
  input  logic [NUM_TGT-1:0] tWready,
  output logic [DATA_W-1:0] tWdata,
  output logic tWlast,
  input  logic [NUM_TGT-1:0] tBvalid,
  output logic [NUM_TGT-1:0] tBready,
  input  logic [2*NUM_TGT-1:0] tBresp,
  output logic [NUM_TGT-1:0] tArvalid,
  input  logic [NUM_TGT-1:0] tArready,
  output logic [ADDR_W-1:0] tAraddr,
  output logic [2:0] tArprot,
  output logic [LEN_W-1:0] tArlen,
  input  logic [NUM_TGT-1:0] tRvalid,
  output logic [NUM_TGT-1:0] tRready,
  input  logic [DATA_W*NUM_TGT-1:0] tRdata,
  input  logic [2*NUM_TGT-1:0] tRresp,
  input  logic [NUM_TGT-1:0] tRlast
);

  localparam int TGT_W = $clog2(NUM_TGT);

  strobes_t st;
  logic [TGT_W-1:0] awTgt, arTgt;
  logic awBlocked, arBlocked;
  logic selAwready, selWready, selBvalid, selArready, selRvalid, selRlast;

  // one checker per address channel
  secfilt_decode #(.ADDR_W(ADDR_W), .NUM_TGT(NUM_TGT), .WIN_LOG2(WIN_LOG2), .MODE(MODE),
    .NUM_REG(NUM_REG), .REG_BASE(REG_BASE), .REG_SIZE_LOG2(REG_SIZE_LOG2), .REG_SECURE(REG_SECURE))
    u_awDec (.addr(mAwaddr), .nonSecure(mAwprot[1]), .tgt(awTgt), .blocked(awBlocked));

  secfilt_decode #(.ADDR_W(ADDR_W), .NUM_TGT(NUM_TGT), .WIN_LOG2(WIN_LOG2), .MODE(MODE),
    .NUM_REG(NUM_REG), .REG_BASE(REG_BASE), .REG_SIZE_LOG2(REG_SIZE_LOG2), .REG_SECURE(REG_SECURE))
    u_arDec (.addr(mAraddr), .nonSecure(mArprot[1]), .tgt(arTgt), .blocked(arBlocked));

  secfilt_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .awvalid(mAwvalid), .awBlocked(awBlocked), .selAwready(selAwready),
    .wvalid(mWvalid), .wlast(mWlast), .selWready(selWready),
    .bready(mBready), .selBvalid(selBvalid),
    .arvalid(mArvalid), .arBlocked(arBlocked), .arlen(mArlen), .selArready(selArready),
    .rready(mRready), .selRvalid(selRvalid), .selRlast(selRlast),
    .st(st), .awready(mAwready), .wready(mWready), .bvalid(mBvalid),
    .arready(mArready), .rvalid(mRvalid)
  );

  secfilt_dpath #(.DATA_W(DATA_W), .NUM_TGT(NUM_TGT)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .awTgt(awTgt), .arTgt(arTgt),
    .mWvalid(mWvalid), .mBready(mBready), .mRready(mRready),
    .tAwready(tAwready), .tWready(tWready), .tBvalid(tBvalid), .tBresp(tBresp),
    .tArready(tArready), .tRvalid(tRvalid), .tRdata(tRdata), .tRresp(tRresp), .tRlast(tRlast),
    .tAwvalid(tAwvalid), .tWvalid(tWvalid), .tBready(tBready), .tArvalid(tArvalid), .tRready(tRready),
    .selAwready(selAwready), .selWready(selWready), .selBvalid(selBvalid),
    .selArready(selArready), .selRvalid(selRvalid), .selRlast(selRlast),
    .mBresp(mBresp), .mRdata(mRdata), .mRresp(mRresp), .mRlast(mRlast)
  );

  // address, length and data fan out to every target; valids pick one
  assign tAwaddr = mAwaddr;
  assign tAwprot = mAwprot;
  assign tAwlen  = mAwlen;
  assign tAraddr = mAraddr;
  assign tArprot = mArprot;
  assign tArlen  = mArlen;
  assign tWdata  = mWdata;
  assign tWlast  = mWlast;

  // R4: a refused request never shows a valid to a target
  a_r4_block_aw: assert property (@(posedge clk) disable iff (!rstN)
    (mAwvalid && awBlocked) |-> (tAwvalid == '0));
  a_r4_block_ar: assert property (@(posedge clk) disable iff (!rstN)
    (mArvalid && arBlocked) |-> (tArvalid == '0));

  // R5: at most one target addressed per channel
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tAwvalid) && $onehot0(tArvalid));

  // R8: read valid drops after the last beat is taken
  a_r8_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    (mRvalid && mRready && mRlast) |=> !mRvalid);

  generate
    if (MODE == MODE_ALIAS) begin : g_aliasChk
      // R2: the upper half of the targets is reached only by non-secure requests
      a_r2_alias_upper: assert property (@(posedge clk) disable iff (!rstN)
        (|tAwvalid[NUM_TGT-1:NUM_TGT/2]) |-> mAwprot[1]);
    end
  endgenerate

endmodule

// File: tb/secfilt_tgtmodel.sv
module secfilt_tgtmodel #(
  parameter int NT = 4,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NT-1:0] awvalid,
  output logic [NT-1:0] awready,
  input  logic [NT-1:0] wvalid,
  input  logic wlast,
  output logic [NT-1:0] wready,
  output logic [NT-1:0] bvalid,
  output logic [2*NT-1:0] bresp,
  input  logic [NT-1:0] bready,
  input  logic [NT-1:0] arvalid,
  input  logic [LW-1:0] arlen,
  output logic [NT-1:0] arready,
  output logic [NT-1:0] rvalid,
  output logic [DW*NT-1:0] rdata,
  output logic [2*NT-1:0] rresp,
  output logic [NT-1:0] rlast,
  input  logic [NT-1:0] rready
);

  assign awready = '1;
  assign wready  = '1;
  assign arready = '1;
  assign bresp   = '0;
  assign rresp   = '0;

  for (genvar t = 0; t < NT; t++) begin : g_t
    logic bv, rv;
    logic [LW-1:0] cnt, len;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bv <= 1'b0; rv <= 1'b0; cnt <= '0; len <= '0;
      end else begin
        if (wvalid[t] && wlast) bv <= 1'b1;
        else if (bready[t]) bv <= 1'b0;
        if (arvalid[t]) begin
          rv <= 1'b1; len <= arlen; cnt <= '0;
        end else if (rv && rready[t]) begin
          if (cnt == len) rv <= 1'b0;
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign bvalid[t] = bv;
    assign rvalid[t] = rv;
    assign rlast[t]  = rv && (cnt == len);
    assign rdata[t*DW +: DW] = 32'hA000_0000 | (t << 8) | 32'(cnt);
  end

endmodule

// File: tb/secfilt_test.sv
`timescale 1ns/1ps
module secfilt_test;
  import secfilt_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int readBeats = 0;

  // shared master stimulus
  logic mAwvalid = 0, mWvalid = 0, mWlast = 0, mBready = 0, mArvalid = 0, mRready = 0;
  logic [31:0] mAwaddr = 0, mAraddr = 0, mWdata = 0;
  logic [2:0] mAwprot = 0, mArprot = 0;
  logic [7:0] mAwlen = 0, mArlen = 0;

  // gating instance signals
  logic gAwready, gWready, gBvalid, gArready, gRvalid, gRlast;
  logic [1:0] gBresp, gRresp;
  logic [31:0] gRdata;
  logic [3:0] gTAwvalid, gTAwready, gTWvalid, gTWready, gTBvalid, gTBready;
  logic [3:0] gTArvalid, gTArready, gTRvalid, gTRready, gTRlast;
  logic [31:0] gTAwaddr, gTAraddr, gTWdata;
  logic [2:0] gTAwprot, gTArprot;
  logic [7:0] gTAwlen, gTArlen, gTBresp, gTRresp;
  logic gTWlast;
  logic [127:0] gTRdata;

  // alias instance signals
  logic aAwready, aWready, aBvalid, aArready, aRvalid, aRlast;
  logic [1:0] aBresp, aRresp;
  logic [31:0] aRdata;
  logic [3:0] aTAwvalid, aTAwready, aTWvalid, aTWready, aTBvalid, aTBready;
  logic [3:0] aTArvalid, aTArready, aTRvalid, aTRready, aTRlast;
  logic [31:0] aTAwaddr, aTAraddr, aTWdata;
  logic [2:0] aTAwprot, aTArprot;
  logic [7:0] aTAwlen, aTArlen, aTBresp, aTRresp;
  logic aTWlast;
  logic [127:0] aTRdata;

  secfilt #(.MODE(MODE_GATE)) uut (
    .clk(clk), .rstN(rstN),
    .mAwvalid(mAwvalid), .mAwready(gAwready), .mAwaddr(mAwaddr), .mAwprot(mAwprot), .mAwlen(mAwlen),
    .mWvalid(mWvalid), .mWready(gWready), .mWdata(mWdata), .mWlast(mWlast),
    .mBvalid(gBvalid), .mBready(mBready), .mBresp(gBresp),
    .mArvalid(mArvalid), .mArready(gArready), .mAraddr(mAraddr), .mArprot(mArprot), .mArlen(mArlen),
    .mRvalid(gRvalid), .mRready(mRready), .mRdata(gRdata), .mRresp(gRresp), .mRlast(gRlast),
    .tAwvalid(gTAwvalid), .tAwready(gTAwready), .tAwaddr(gTAwaddr), .tAwprot(gTAwprot), .tAwlen(gTAwlen),
    .tWvalid(gTWvalid), .tWready(gTWready), .tWdata(gTWdata), .tWlast(gTWlast),
    .tBvalid(gTBvalid), .tBready(gTBready), .tBresp(gTBresp),
    .tArvalid(gTArvalid), .tArready(gTArready), .tAraddr(gTAraddr), .tArprot(gTArprot), .tArlen(gTArlen),
    .tRvalid(gTRvalid), .tRready(gTRready), .tRdata(gTRdata), .tRresp(gTRresp), .tRlast(gTRlast)
  );

  secfilt_tgtmodel u_gTgt (
    .clk(clk), .rstN(rstN), .awvalid(gTAwvalid), .awready(gTAwready),
    .wvalid(gTWvalid), .wlast(gTWlast), .wready(gTWready),
    .bvalid(gTBvalid), .bresp(gTBresp), .bready(gTBready),
    .arvalid(gTArvalid), .arlen(gTArlen), .arready(gTArready),
    .rvalid(gTRvalid), .rdata(gTRdata), .rresp(gTRresp), .rlast(gTRlast), .rready(gTRready)
  );

  secfilt #(.MODE(MODE_ALIAS)) uutAlias (
    .clk(clk), .rstN(rstN),
    .mAwvalid(mAwvalid), .mAwready(aAwready), .mAwaddr(mAwaddr), .mAwprot(mAwprot), .mAwlen(mAwlen),
    .mWvalid(mWvalid), .mWready(aWready), .mWdata(mWdata), .mWlast(mWlast),
    .mBvalid(aBvalid), .mBready(mBready), .mBresp(aBresp),
    .mArvalid(mArvalid), .mArready(aArready), .mAraddr(mAraddr), .mArprot(mArprot), .mArlen(mArlen),
    .mRvalid(aRvalid), .mRready(mRready), .mRdata(aRdata), .mRresp(aRresp), .mRlast(aRlast),
    .tAwvalid(aTAwvalid), .tAwready(aTAwready), .tAwaddr(aTAwaddr), .tAwprot(aTAwprot), .tAwlen(aTAwlen),
    .tWvalid(aTWvalid), .tWready(aTWready), .tWdata(aTWdata), .tWlast(aTWlast),
    .tBvalid(aTBvalid), .tBready(aTBready), .tBresp(aTBresp),
    .tArvalid(aTArvalid), .tArready(aTArready), .tAraddr(aTAraddr), .tArprot(aTArprot), .tArlen(aTArlen),
    .tRvalid(aTRvalid), .tRready(aTRready), .tRdata(aTRdata), .tRresp(aTRresp), .tRlast(aTRlast)
  );

  secfilt_tgtmodel u_aTgt (
    .clk(clk), .rstN(rstN), .awvalid(aTAwvalid), .awready(aTAwready),
    .wvalid(aTWvalid), .wlast(aTWlast), .wready(aTWready),
    .bvalid(aTBvalid), .bresp(aTBresp), .bready(aTBready),
    .arvalid(aTArvalid), .arlen(aTArlen), .arready(aTArready),
    .rvalid(aTRvalid), .rdata(aTRdata), .rresp(aTRresp), .rlast(aTRlast), .rready(aTRready)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference: region list and target maps
  function automatic bit refBlocked(logic [31:0] a, bit ns);
    if (!ns) return 1'b0;
    if (a >= 32'h1000 && a < 32'h1800) return 1'b0;  // region 0 open, wins overlap
    if (a >= 32'h1000 && a < 32'h2000) return 1'b1;  // region 1 secure
    if (a >= 32'h3000 && a < 32'h4000) return 1'b1;  // region 2 secure
    return 1'b0;
  endfunction
  function automatic int refGateTgt(logic [31:0] a);
    return int'((a >> 12) & 32'd3);
  endfunction
  function automatic int refAliasTgt(logic [31:0] a, bit ns);
    return (ns ? 2 : 0) + int'((a >> 12) & 32'd1);
  endfunction

  task automatic writeTxn(logic [31:0] addr, logic [2:0] prot, int len, string req);
    bit blk = refBlocked(addr, prot[1]);
    logic [3:0] gVec = blk ? 4'b0 : (4'b1 << refGateTgt(addr));
    logic [3:0] aVec = 4'b1 << refAliasTgt(addr, prot[1]);
    @(negedge clk);
    mAwaddr = addr; mAwprot = prot; mAwlen = 8'(len); mAwvalid = 1;
    #1;
    chk(req, "gate awready", gAwready, 1);
    chk(req, "gate target awvalid", gTAwvalid, gVec);
    chk("R2", "alias target awvalid", aTAwvalid, aVec);
    @(posedge clk);
    @(negedge clk);
    mAwvalid = 0;
    for (int b = 0; b <= len; b++) begin
      mWvalid = 1; mWdata = addr + 32'(b); mWlast = (b == len);
      #1;
      chk(blk ? "R7" : "R10", "gate wready", gWready, 1);
      chk(blk ? "R7" : "R10", "gate target wvalid", gTWvalid, gVec);
      chk("R10", "alias target wvalid", aTWvalid, aVec);
      if (b == 0) chk("R10", "alias target wdata", aTWdata, addr);
      @(posedge clk);
      @(negedge clk);
    end
    mWvalid = 0; mWlast = 0; mBready = 1;
    #1;
    chk(blk ? "R7" : "R10", "gate bvalid", gBvalid, 1);
    chk(blk ? "R7" : "R10", "gate bresp", gBresp, blk ? RESP_SLVERR : RESP_OKAY);
    chk("R10", "alias bvalid", aBvalid, 1);
    chk("R10", "alias bresp", aBresp, RESP_OKAY);
    @(posedge clk);
    @(negedge clk);
    mBready = 0;
    #1;
    chk("R7", "gate single response", gBvalid, 0);
    chk("R10", "alias single response", aBvalid, 0);
  endtask

  task automatic readTxn(logic [31:0] addr, logic [2:0] prot, int len, int hold, string req);
    bit blk = refBlocked(addr, prot[1]);
    int gt = refGateTgt(addr);
    int at = refAliasTgt(addr, prot[1]);
    logic [3:0] gVec = blk ? 4'b0 : (4'b1 << gt);
    logic [3:0] aVec = 4'b1 << at;
    @(negedge clk);
    mAraddr = addr; mArprot = prot; mArlen = 8'(len); mArvalid = 1;
    #1;
    chk(req, "gate arready", gArready, 1);
    chk(req, "gate target arvalid", gTArvalid, gVec);
    chk("R2", "alias target arvalid", aTArvalid, aVec);
    @(posedge clk);
    @(negedge clk);
    mArvalid = 0;
    for (int h = 0; h < hold; h++) begin
      #1;
      chk("R8", "gate rvalid held", gRvalid, 1);
      chk("R10", "alias rvalid held", aRvalid, 1);
      @(negedge clk);
    end
    for (int b = 0; b <= len; b++) begin
      mRready = 1;
      #1;
      chk(blk ? "R8" : "R10", "gate rvalid", gRvalid, 1);
      chk(blk ? "R8" : "R10", "gate rresp", gRresp, blk ? RESP_SLVERR : RESP_OKAY);
      chk(blk ? "R8" : "R10", "gate rdata", gRdata, blk ? 32'h0 : (32'hA000_0000 | (gt << 8) | b));
      chk(blk ? "R8" : "R10", "gate rlast", gRlast, b == len);
      chk("R10", "alias rdata", aRdata, 32'hA000_0000 | (at << 8) | b);
      chk("R10", "alias rlast", aRlast, b == len);
      readBeats++;
      @(posedge clk);
      @(negedge clk);
    end
    mRready = 0;
    #1;
    chk("R8", "gate rvalid after last", gRvalid, 0);
    chk("R10", "alias rvalid after last", aRvalid, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset gate target valids", {gTAwvalid, gTArvalid, gTWvalid}, 0);
    chk("R1", "reset alias target valids", {aTAwvalid, aTArvalid, aTWvalid}, 0);
    chk("R1", "reset master valids", {gBvalid, gRvalid, aBvalid, aRvalid}, 0);
    rstN = 1;

    // same address, attribute flipped: R3, R4, R5, R2
    writeTxn(32'h1900, 3'b000, 2, "R5");
    writeTxn(32'h1900, 3'b010, 2, "R4");
    readTxn(32'h3010, 3'b000, 3, 0, "R3");
    readTxn(32'h3010, 3'b010, 3, 2, "R4");
    // region overlap and boundaries: R6
    writeTxn(32'h1100, 3'b010, 0, "R6");
    writeTxn(32'h1FFC, 3'b010, 0, "R6");
    readTxn(32'h17FC, 3'b010, 0, 0, "R6");
    // unmatched address for non-secure, secure to plain window: R5
    readTxn(32'h2000, 3'b010, 0, 0, "R5");
    readTxn(32'h0800, 3'b000, 1, 0, "R3");

    // R9: write completes while a refused read waits on ready
    readBeats = 0;
    fork
      readTxn(32'h3000, 3'b010, 3, 10, "R9");
      begin
        repeat (2) @(negedge clk);
        writeTxn(32'h0040, 3'b010, 1, "R9");
        chk("R9", "write done before read beats", readBeats, 0);
      end
    join

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule